// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block holds two programmable timers. Each one is a 6-bit prescaler followed by an 8-bit down counter. Both count on a base tick, which is the internal clock divided by four. Software loads the initial values through a small write port. The current count of either timer can be read at any moment without disturbing it. Each timer can stop after one terminal count or reload itself and run on. Each timer raises its own one-cycle interrupt at the end of a count.

The second timer has more ways to be clocked. It can use the base tick, or rising edges on an external pin. It can use the base tick gated by that pin's level. It can also wait for a pin edge that starts a count, which is trigger mode, either retriggerable or not. Cascaded mode is a separate setting: the second timer then advances once per terminal count of the first timer. One shared output pin shows one of four things: a level that toggles at the first timer's terminal count, a level that toggles at the second timer's terminal count, the base timebase square wave, or a constant low.

Register map (8-bit data):
- Address 0, control: bit0 loads timer 0, bit1 enables timer 0, bit2 loads timer 1, bit3 enables timer 1.
- Address 1, timer 0 prescale: initial value in bits [5:0], auto-reload mode in bit 6.
- Address 2, timer 0 count initial value.
- Address 3, timer 1 prescale: initial value in bits [5:0], auto-reload mode in bit 6.
- Address 4, timer 1 count initial value.
- Address 5, configuration: timer 1 source in [1:0], retrigger in bit 2, cascade in bit 3, output select in [5:4].
- Address 6, timer 0 live count (read).
- Address 7, timer 1 live count (read).

Top module: `twin_timer`

## Requirements
- R1: A running, enabled timer moves its prescaler one step per base tick, which is one clock in every four after reset. Each time the prescaler passes its terminal value, the counter steps down by one. A prescale initial value of 0 means 64 ticks, and a count initial value of 0 means 256 prescaler periods.
- R2: Writing address 0 stores the two enable bits (bit1, bit3). Within the same write, a 1 in bit0 or bit2 copies that timer's initial values into its prescaler and counter at that clock edge and marks it running. Reading address 0 returns {en1,en0} in bits [1:0], and reading address 5 returns the stored configuration.
- R3: With bit 6 of the prescale register at 0 (single pass), the counter goes to 0 at the terminal count and stops. With bit 6 at 1 (auto-reload), the counter takes its initial value again and keeps counting.
- R4: Addresses 6 and 7 read the live counts, and reading them leaves the count unchanged. Addresses 1 and 3 read back only the mode bit in bit 6; the prescaler value is never readable.
- R5: irq_t0 and irq_t1 each pulse high for exactly one clock, in the cycle after the terminal count of their timer.
- R6: Configuration bits [1:0] pick the timer 1 source: 0 is the base tick, 1 is a rising edge on ext_pin, 2 is the base tick while ext_pin is high, and 3 is trigger mode. ext_pin passes through two synchronizing flops before it is used.
- R7: In trigger mode, a load only arms timer 1 and does not start it. A synchronized rising edge on an enabled timer 1 reloads and starts it. With bit 2 set, an edge that arrives during a count restarts that count; with bit 2 clear, such an edge is ignored.
- R8: With configuration bit 3 set, timer 1 advances once per timer 0 terminal count, whatever bits [1:0] say, and trigger mode is inactive.
- R9: Configuration bits [5:4] select tmr_out: 0 is a level toggling at each timer 0 terminal count, 1 is a level toggling at each timer 1 terminal count, 2 is the base divider's top bit, and 3 is constant low.
- R10: After reset, all counts, registers, interrupts and tmr_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ext_pin | input | 1 | External input for timer 1 (asynchronous) |
| irq_t0 | output | 1 | Timer 0 terminal-count pulse |
| irq_t1 | output | 1 | Timer 1 terminal-count pulse |
| tmr_out | output | 1 | Shared timer output |

## Verification
The situation hardest to reach from the ports is a non-retriggerable edge that lands in the middle of a count. It needs timer 1 armed in trigger mode and already started by an earlier edge. The second pin edge must then arrive after the two-flop synchronizer delay but before the count ends. The stimulus gets there with pulse trains spaced closer together than one full count, and plays the same train once with retriggering and once without, so the two results must differ. The zero-means-full-range cases are reached by loading a prescale value of 0 and, separately, a count value of 0, each with a short partner value, so the run stays within about a thousand cycles.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

  typedef enum logic [1:0] {
    SRC_DIV     = 2'd0,
    SRC_EXT_CLK = 2'd1,
    SRC_GATE    = 2'd2,
    SRC_TRIG    = 2'd3
  } t1_src_e;

  typedef enum logic [1:0] {
    OUT_T0   = 2'd0,
    OUT_T1   = 2'd1,
    OUT_BASE = 2'd2,
    OUT_LOW  = 2'd3
  } out_sel_e;

  typedef struct packed {
    out_sel_e osel;
    logic     casc;
    logic     retrig;
    t1_src_e  src;
  } cfg_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PRE0 = 3'd1;
  localparam logic [2:0] A_CNT0 = 3'd2;
  localparam logic [2:0] A_PRE1 = 3'd3;
  localparam logic [2:0] A_CNT1 = 3'd4;
  localparam logic [2:0] A_CFG  = 3'd5;
  localparam logic [2:0] A_RD0  = 3'd6;
  localparam logic [2:0] A_RD1  = 3'd7;

  localparam int MODE_BIT = 6;

endpackage

// File: rtl/twin_timer_base.sv
module twin_timer_base #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pin,
  output logic base_tick,
  output logic base_lvl,
  output logic ext_rise,
  output logic ext_lvl
);
  localparam int SYNC_N = 3;

  logic [DIV_W-1:0]  div;
  logic [SYNC_N-1:0] sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div  <= '0;
      sync <= '0;
    end else begin
      div  <= div + DIV_W'(1);
      sync <= {sync[SYNC_N-2:0], ext_pin};
    end
  end

  assign base_tick = &div;
  assign base_lvl  = div[DIV_W-1];
  assign ext_lvl   = sync[1];
  assign ext_rise  = sync[1] & ~sync[2];
endmodule

// File: rtl/twin_timer_regs.sv
module twin_timer_regs
  import twin_timer_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  output logic             ld0,
  output logic             ld1,
  output logic             en0,
  output logic             en1,
  output logic             mode0,
  output logic             mode1,
  output logic [PRE_W-1:0] pinit0,
  output logic [PRE_W-1:0] pinit1,
  output logic [CNT_W-1:0] cinit0,
  output logic [CNT_W-1:0] cinit1,
  output cfg_t             cfg
);
  localparam int CFG_W = $bits(cfg_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en0    <= 1'b0;
      en1    <= 1'b0;
      mode0  <= 1'b0;
      mode1  <= 1'b0;
      pinit0 <= '0;
      pinit1 <= '0;
      cinit0 <= '0;
      cinit1 <= '0;
      cfg    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          en0 <= wr_data[1];
          en1 <= wr_data[3];
        end
        A_PRE0: begin
          pinit0 <= wr_data[PRE_W-1:0];
          mode0  <= wr_data[MODE_BIT];
        end
        A_CNT0: cinit0 <= wr_data[CNT_W-1:0];
        A_PRE1: begin
          pinit1 <= wr_data[PRE_W-1:0];
          mode1  <= wr_data[MODE_BIT];
        end
        A_CNT1: cinit1 <= wr_data[CNT_W-1:0];
        A_CFG:  cfg    <= cfg_t'(wr_data[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  assign ld0 = wr_en && (wr_addr == A_CTRL) && wr_data[0];
  assign ld1 = wr_en && (wr_addr == A_CTRL) && wr_data[2];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = {6'b0, en1, en0};
      A_PRE0: rd_data[MODE_BIT] = mode0;
      A_CNT0: rd_data = 8'(cinit0);
      A_PRE1: rd_data[MODE_BIT] = mode1;
      A_CNT1: rd_data = 8'(cinit1);
      A_CFG:  rd_data = 8'(cfg);
      A_RD0:  rd_data = 8'(cnt0);
      A_RD1:  rd_data = 8'(cnt1);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/twin_timer_chan.sv
module twin_timer_chan #(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             arm_only,
  input  logic             start,
  input  logic             tick,
  input  logic             en,
  input  logic             reload,
  input  logic [PRE_W-1:0] pinit,
  input  logic [CNT_W-1:0] cinit,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             step,
  output logic             eoc
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [PRE_W-1:0] pre;

  // Down-step that wraps 0 to all-ones, so 0 acts as the full range.
  function automatic logic [PRE_W-1:0] pre_dec(input logic [PRE_W-1:0] v);
    return v - PRE_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic at_end(input logic [PRE_W-1:0] p,
                                  input logic [CNT_W-1:0] c);
    return (p == PRE_LAST) && (c == CNT_LAST);
  endfunction

  assign step = en && running && tick && !load && !start;
  assign eoc  = step && at_end(pre, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      running <= 1'b0;
    end else if (load || start) begin
      pre     <= pinit;
      cnt     <= cinit;
      running <= load ? !arm_only : 1'b1;
    end else if (step) begin
      if (pre == PRE_LAST) begin
        pre <= pinit;
        if (cnt == CNT_LAST) begin
          cnt     <= reload ? cinit : '0;
          running <= reload;
        end else begin
          cnt <= cnt_dec(cnt);
        end
      end else begin
        pre <= pre_dec(pre);
      end
    end
  end
endmodule

// File: rtl/twin_timer_out.sv
module twin_timer_out
  import twin_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  out_sel_e osel,
  input  logic     eoc0,
  input  logic     eoc1,
  input  logic     base_lvl,
  output logic     tog,
  output logic     tout
);
  logic hit;

  assign hit = ((osel == OUT_T0) && eoc0) || ((osel == OUT_T1) && eoc1);

  always_ff @(posedge clk) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= tog ^ hit;
  end

  always_comb begin
    case (osel)
      OUT_T0, OUT_T1: tout = tog;
      OUT_BASE:       tout = base_lvl;
      default:        tout = 1'b0;
    endcase
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8,
  parameter int DIV_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       ext_pin,
  output logic       irq_t0,
  output logic       irq_t1,
  output logic       tmr_out
);
  logic             base_tick, base_lvl, ext_rise, ext_lvl;
  logic             ld0, ld1, en0, en1, mode0, mode1;
  logic [PRE_W-1:0] pinit0, pinit1;
  logic [CNT_W-1:0] cinit0, cinit1, cnt0, cnt1;
  cfg_t             cfg;
  logic             run0, run1, step0, step1, eoc0, eoc1;
  logic             tick1, trig_mode, trig_fire, tog;

  twin_timer_base #(.DIV_W(DIV_W)) u_base (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
    .base_tick(base_tick), .base_lvl(base_lvl),
    .ext_rise(ext_rise), .ext_lvl(ext_lvl)
  );

  twin_timer_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt0(cnt0), .cnt1(cnt1),
    .ld0(ld0), .ld1(ld1), .en0(en0), .en1(en1),
    .mode0(mode0), .mode1(mode1),
    .pinit0(pinit0), .pinit1(pinit1),
    .cinit0(cinit0), .cinit1(cinit1),
    .cfg(cfg)
  );

  assign trig_mode = (cfg.src == SRC_TRIG) && !cfg.casc;
  assign trig_fire = trig_mode && ext_rise && en1 && (cfg.retrig || !run1);

  always_comb begin
    if (cfg.casc) begin
      tick1 = eoc0;
    end else begin
      case (cfg.src)
        SRC_EXT_CLK: tick1 = ext_rise;
        SRC_GATE:    tick1 = base_tick && ext_lvl;
        default:     tick1 = base_tick;
      endcase
    end
  end

  twin_timer_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ch0 (
    .clk(clk), .rst_n(rst_n),
    .load(ld0), .arm_only(1'b0), .start(1'b0),
    .tick(base_tick), .en(en0), .reload(mode0),
    .pinit(pinit0), .cinit(cinit0),
    .cnt(cnt0), .running(run0), .step(step0), .eoc(eoc0)
  );

  twin_timer_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ch1 (
    .clk(clk), .rst_n(rst_n),
    .load(ld1), .arm_only(trig_mode), .start(trig_fire),
    .tick(tick1), .en(en1), .reload(mode1),
    .pinit(pinit1), .cinit(cinit1),
    .cnt(cnt1), .running(run1), .step(step1), .eoc(eoc1)
  );

  twin_timer_out u_out (
    .clk(clk), .rst_n(rst_n), .osel(cfg.osel),
    .eoc0(eoc0), .eoc1(eoc1), .base_lvl(base_lvl),
    .tog(tog), .tout(tmr_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_t0 <= 1'b0;
      irq_t1 <= 1'b0;
    end else begin
      irq_t0 <= eoc0;
      irq_t1 <= eoc1;
    end
  end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld0,
  input logic             ld1,
  input logic             base_tick,
  input logic             tick1,
  input logic             eoc0,
  input logic             mode0,
  input logic [CNT_W-1:0] cinit0,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic             irq_t0,
  input logic             irq_t1,
  input logic             tog,
  input logic [1:0]       osel,
  input logic             trig_mode,
  input logic             retrig,
  input logic             run1,
  input logic             ext_rise
);
  AST_CNT0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld0 && !base_tick |=> $stable(cnt0)); // R1
  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    eoc0 && !mode0 |=> cnt0 == '0); // R3
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    eoc0 && mode0 |=> cnt0 == $past(cinit0)); // R3
  AST_IRQ0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t0 |=> !irq_t0); // R5
  AST_IRQ1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t1 |=> !irq_t1); // R5
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_mode && !retrig && run1 && ext_rise && !ld1 && !tick1 |=> $stable(cnt1)); // R7
  AST_OUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (osel == 2'd0) && eoc0 |=> tog != $past(tog)); // R9
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld0(ld0), .ld1(ld1),
  .base_tick(base_tick), .tick1(tick1), .eoc0(eoc0), .mode0(mode0),
  .cinit0(cinit0), .cnt0(cnt0), .cnt1(cnt1),
  .irq_t0(irq_t0), .irq_t1(irq_t1), .tog(tog), .osel(cfg.osel),
  .trig_mode(trig_mode), .retrig(cfg.retrig), .run1(run1), .ext_rise(ext_rise)
);

// File: tb/sim_twin_timer.sv
module sim_twin_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_pin = 1'b0;
  logic       irq_t0, irq_t1, tmr_out;

  always #10 clk = ~clk;

  twin_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_pin(ext_pin), .irq_t0(irq_t0), .irq_t1(irq_t1), .tmr_out(tmr_out)
  );

  int checks = 0;
  int fails = 0;
  int n_irq0 = 0;
  string cur_tag = "R1";

  // Behavioural reference state
  int m_div, m_s1, m_s2, m_s3, m_src, m_sel;
  int m_pre[2], m_cnt[2], m_pi[2], m_ci[2];
  bit m_run[2], m_en[2], m_mode[2], m_irq[2];
  bit m_rt, m_cs, m_tq;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit adv(int i);
    bit hit = 0;
    if (m_pre[i] == 1) begin
      m_pre[i] = m_pi[i];
      if (m_cnt[i] == 1) begin
        hit = 1;
        if (m_mode[i]) m_cnt[i] = m_ci[i];
        else begin m_cnt[i] = 0; m_run[i] = 0; end
      end else m_cnt[i] = (m_cnt[i] + 255) % 256;
    end else m_pre[i] = (m_pre[i] + 63) % 64;
    return hit;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return m_en[1] * 2 + m_en[0];
      1: return m_mode[0] * 64;
      2: return m_ci[0];
      3: return m_mode[1] * 64;
      4: return m_ci[1];
      5: return m_src + m_rt * 4 + m_cs * 8 + m_sel * 16;
      6: return m_cnt[0];
      default: return m_cnt[1];
    endcase
  endfunction

  function automatic int exp_out();
    if (m_sel == 2) return (m_div / 2) % 2;
    if (m_sel == 3) return 0;
    return m_tq;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_src = 0; m_sel = 0;
      m_rt = 0; m_cs = 0; m_tq = 0;
      for (int i = 0; i < 2; i++) begin
        m_pre[i] = 0; m_cnt[i] = 0; m_pi[i] = 0; m_ci[i] = 0;
        m_run[i] = 0; m_en[i] = 0; m_mode[i] = 0; m_irq[i] = 0;
      end
    end else begin
      bit base, rise, lvl, l0, l1, trig, fire, e0, e1, t1;
      base = (m_div == 3);
      rise = m_s2 && !m_s3;
      lvl  = m_s2;
      l0 = wr_en && wr_addr == 0 && wr_data[0];
      l1 = wr_en && wr_addr == 0 && wr_data[2];
      trig = (m_src == 3) && !m_cs;
      e0 = 0; e1 = 0;
      if (l0) begin m_pre[0] = m_pi[0]; m_cnt[0] = m_ci[0]; m_run[0] = 1; end
      else if (m_en[0] && m_run[0] && base) e0 = adv(0);
      if (m_cs) t1 = e0;
      else if (m_src == 1) t1 = rise;
      else if (m_src == 2) t1 = base && lvl;
      else t1 = base;
      fire = trig && rise && m_en[1] && (m_rt || !m_run[1]);
      if (l1) begin m_pre[1] = m_pi[1]; m_cnt[1] = m_ci[1]; m_run[1] = !trig; end
      else if (fire) begin m_pre[1] = m_pi[1]; m_cnt[1] = m_ci[1]; m_run[1] = 1; end
      else if (m_en[1] && m_run[1] && t1) e1 = adv(1);
      m_irq[0] = e0; m_irq[1] = e1;
      if ((m_sel == 0 && e0) || (m_sel == 1 && e1)) m_tq = !m_tq;
      m_div = (m_div + 1) % 4;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
      if (wr_en) begin
        case (wr_addr)
          0: begin m_en[0] = wr_data[1]; m_en[1] = wr_data[3]; end
          1: begin m_pi[0] = wr_data[5:0]; m_mode[0] = wr_data[6]; end
          2: m_ci[0] = wr_data;
          3: begin m_pi[1] = wr_data[5:0]; m_mode[1] = wr_data[6]; end
          4: m_ci[1] = wr_data;
          5: begin
            m_src = wr_data[1:0]; m_rt = wr_data[2];
            m_cs = wr_data[3]; m_sel = wr_data[5:4];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk((rd_addr >= 6) ? cur_tag : ((rd_addr == 1 || rd_addr == 3) ? "R4" : "R2"),
          rd_data, exp_rd(rd_addr));
      chk("R5", irq_t0, m_irq[0]);
      chk("R5", irq_t1, m_irq[1]);
      chk("R9", tmr_out, exp_out());
      if (irq_t0) n_irq0++;
    end else begin
      chk("R10", rd_data, 0);
      chk("R10", irq_t0, 0);
      chk("R10", irq_t1, 0);
      chk("R10", tmr_out, 0);
    end
    rd_addr <= rd_addr + 3'd1;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int k = 0; k < n; k++) begin
      ext_pin = 1'b1; idle(hi);
      ext_pin = 1'b0; idle(lo);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(16);                      // R10: reset state observed every cycle
    rst_n = 1'b1;
    idle(4);
    cur_tag = "R1";                // prescaled auto-reload on timer 0
    wr(1, 8'h42); wr(2, 8'd3); wr(5, 8'h00); wr(0, 8'h03);
    idle(120);
    cur_tag = "R3";                // single pass stops at zero
    wr(1, 8'h01); wr(2, 8'd2); wr(0, 8'h03);
    n_irq0 = 0;
    idle(40);
    chk("R3", n_irq0, 1);
    chk("R3", int'(m_run[0]), 0);
    cur_tag = "R1";                // zero means full range
    wr(1, 8'h40); wr(2, 8'd2); wr(0, 8'h03);
    idle(520);
    wr(1, 8'h41); wr(2, 8'd0); wr(0, 8'h03);
    idle(1040);
    wr(0, 8'h00);
    cur_tag = "R6";                // external clock, then gate
    wr(3, 8'h41); wr(4, 8'd3); wr(5, 8'h11); wr(0, 8'h0C);
    pulses(40, 3, 3);
    wr(5, 8'h12); wr(0, 8'h0C);
    ext_pin = 1'b1; idle(40); ext_pin = 1'b0; idle(40); ext_pin = 1'b1; idle(40);
    ext_pin = 1'b0;
    cur_tag = "R7";                // retriggerable then non-retriggerable
    wr(3, 8'h01); wr(4, 8'd5); wr(5, 8'h17); wr(0, 8'h0C);
    idle(10);
    pulses(6, 3, 7);
    idle(40);
    wr(5, 8'h13); wr(0, 8'h0C);
    idle(10);
    pulses(6, 3, 7);
    idle(40);
    cur_tag = "R8";                // cascade
    wr(1, 8'h41); wr(2, 8'd2); wr(3, 8'h41); wr(4, 8'd3);
    wr(5, 8'h08); wr(0, 8'h0F);
    idle(200);
    cur_tag = "R9";
    wr(5, 8'h28); idle(20);
    wr(5, 8'h38); idle(10);
    wr(5, 8'h18); idle(60);
    wr(0, 8'h00); idle(8);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule